// File: doc/BRIEF.md
# Minimum Dead-Band Enforcement Unit

This block follows a two-channel PWM generator and guarantees that each PWM output is held off, or held on, for at least a programmed number of system-clock cycles around edges of a chosen reference. Each channel picks its reference from one of two places: its own output as it stood before high-resolution adjustment, or one of fifteen external candidates. The reference can be inverted before use. It is then turned into a blocking pulse that stays high for as long as the reference is high, and for a programmed number of cycles after the reference falls.

Each channel applies either its own blocking pulse or the other channel's. The pulse acts in one of two ways. As an inhibit, the output is the PWM ANDed with the inverted block. As a force, the output is the PWM ORed with the block. When a channel is disabled, its PWM passes straight through. In both cases the output is registered, so the latency is always one cycle.

Two 32-bit words hold the controls. Software writes them through a simple synchronous port and can read them back at any time through a combinational port.

Top module: `mindb_guard`

## Requirements
- R1: After a synchronous reset, every control and delay field reads 0, and both outputs are 0 for as long as reset is held.
- R2: With a channel's enable bit (bit 0 of its half of the control word) clear, the output equals that channel's PWM input from the previous clock cycle.
- R3: Reference select (bits 7:4 of the channel half) works as follows. Code 0 takes the channel's pre-dead-band input. Code k from 1 to 15 takes ext_ref[k-1]. Candidates that are not selected have no effect on the output.
- R4: When the invert bit (bit 2 of the channel half) is set, the chosen reference is complemented before the blocking logic sees it.
- R5: A channel's blocking pulse is high while its conditioned reference is high. It stays high for exactly D further cycles after the reference falls, where D is the channel's delay field, and a reference that rises again during the stretch restarts it.
- R6: A delay field of 0 behaves as a stretch of exactly 1 cycle.
- R7: When the block-source bit (bit 3 of the channel half) is 0, the channel uses its own blocking pulse. When it is 1, the channel uses the other channel's blocking pulse, and its own reference then has no effect on its output.
- R8: When the polarity bit (bit 8 of the channel half) is 0, the output is PWM AND NOT block. When it is 1, the output is PWM OR block.
- R9: In the control word (address 0), channel A occupies bits 15:0 and channel B occupies bits 31:16. All bits other than 0, 2, 3, 7:4 and 8 of each half read back as 0. In the delay word (address 1), channel A's delay is in bits 15:0 and channel B's in bits 31:16, all readable.
- R10: A new delay value applies from the next falling edge of the conditioned reference. A stretch already in progress is neither shortened nor lengthened by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control word, 1 delay word |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 control word, 1 delay word |
| rd_data | output | 32 | Combinational read-back of the addressed word |
| pwm_a | input | 1 | Channel A PWM to be guarded |
| pwm_b | input | 1 | Channel B PWM to be guarded |
| pre_db_a | input | 1 | Channel A pre-high-resolution dead-band output (reference code 0) |
| pre_db_b | input | 1 | Channel B pre-high-resolution dead-band output (reference code 0) |
| ext_ref | input | 15 | External reference candidates; bit k serves code k+1 |
| out_a | output | 1 | Guarded channel A output, registered |
| out_b | output | 1 | Guarded channel B output, registered |

## Verification
The bench first drives a table-driven sequence on channel A with a 3-cycle delay. In that sequence, a held reference pulse, a PWM low during the free window and a reference that retriggers during a stretch each show a different counter history, so the stretch length and the restart can be told apart from a stretch that ends early. Directed runs then go through each selection path in turn: an external code with the own input toggled against it, inverted references, the force polarity, and borrowing the other channel's pulse while the channel's own reference is held active. Each of these runs exposes a wrong mux leg or a swapped gate. A delay rewritten in the middle of a stretch, and a delay of zero, separate the reload-on-fall rule from an immediate reload. A read-back of all-ones writes exposes any reserved bit that is stored.

// File: rtl/mindb_pkg.sv
package mindb_pkg;

    localparam int SEL_W      = 4;
    localparam int NUM_EXT    = (1 << SEL_W) - 1;
    localparam int DLY_W      = 16;
    localparam int HALF_W     = 16;
    localparam int NUM_CH     = 2;
    localparam int WORD_W     = HALF_W * NUM_CH;

    // bit positions inside one channel half of the control word
    localparam int POS_EN     = 0;
    localparam int POS_INV    = 2;
    localparam int POS_XBLK   = 3;
    localparam int POS_SEL    = 4;
    localparam int POS_POL    = 8;

    localparam logic [HALF_W-1:0] HALF_MASK =
        HALF_W'((1 << POS_EN) | (1 << POS_INV) | (1 << POS_XBLK) |
                (((1 << SEL_W) - 1) << POS_SEL) | (1 << POS_POL));

    typedef enum logic { ADDR_CTRL = 1'b0, ADDR_DLY = 1'b1 } reg_addr_e;

    typedef struct packed {
        logic             pol;
        logic [SEL_W-1:0] sel;
        logic             blk_other;
        logic             inv;
        logic             en;
    } chan_cfg_t;

    function automatic chan_cfg_t cfg_from_bits(input logic [HALF_W-1:0] b);
        chan_cfg_t c;
        c.en        = b[POS_EN];
        c.inv       = b[POS_INV];
        c.blk_other = b[POS_XBLK];
        c.sel       = b[POS_SEL +: SEL_W];
        c.pol       = b[POS_POL];
        return c;
    endfunction

    function automatic logic [HALF_W-1:0] cfg_to_bits(input chan_cfg_t c);
        logic [HALF_W-1:0] b;
        b                     = '0;
        b[POS_EN]             = c.en;
        b[POS_INV]            = c.inv;
        b[POS_XBLK]           = c.blk_other;
        b[POS_SEL +: SEL_W]   = c.sel;
        b[POS_POL]            = c.pol;
        return b;
    endfunction

    // a zero delay field still yields a one-cycle stretch
    function automatic logic [DLY_W-1:0] stretch_len(input logic [DLY_W-1:0] d);
        return (d == '0) ? DLY_W'(1) : d;
    endfunction

endpackage

// File: rtl/mindb_regs.sv
module mindb_regs
    import mindb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic                          rd_addr,
    output logic [WORD_W-1:0]             rd_data,
    output chan_cfg_t [NUM_CH-1:0]        cfg_o,
    output logic [NUM_CH-1:0][DLY_W-1:0]  dly_o
);

    chan_cfg_t [NUM_CH-1:0]        cfg_q;
    logic [NUM_CH-1:0][DLY_W-1:0]  dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            dly_q <= '0;
        end else if (wr_en) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (reg_addr_e'(wr_addr) == ADDR_CTRL)
                    cfg_q[ch] <= cfg_from_bits(wr_data[ch*HALF_W +: HALF_W]);
                else
                    dly_q[ch] <= wr_data[ch*HALF_W +: DLY_W];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (reg_addr_e'(rd_addr) == ADDR_CTRL)
                rd_data[ch*HALF_W +: HALF_W] = cfg_to_bits(cfg_q[ch]);
            else
                rd_data[ch*HALF_W +: DLY_W] = dly_q[ch];
        end
    end

    assign cfg_o = cfg_q;
    assign dly_o = dly_q;

    // R9: reserved control bits never read back as 1
    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 1'b0) |-> ((rd_data & ~{HALF_MASK, HALF_MASK}) == '0));

    // R1: first cycle after reset, all fields are clear
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cfg_q == '0 && dly_q == '0));

endmodule

// File: rtl/mindb_ref_sel.sv
module mindb_ref_sel
    import mindb_pkg::*;
(
    input  logic               own_ref,
    input  logic [NUM_EXT-1:0] ext_ref,
    input  logic [SEL_W-1:0]   sel,
    input  logic               inv,
    output logic               cond_ref
);

    logic [NUM_EXT:0] cand;

    assign cand     = {ext_ref, own_ref};
    assign cond_ref = cand[sel] ^ inv;

endmodule

// File: rtl/mindb_stretch.sv
module mindb_stretch
    import mindb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cond_ref,
    input  logic [DLY_W-1:0] dly,
    output logic             blk
);

    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cond_ref)
            cnt_q <= stretch_len(dly);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign blk = cond_ref | (cnt_q != '0);

    // R5: once the reference is low, the tail counts down by one per cycle
    assert_tail_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cond_ref && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6: the cycle after an active reference is always blocked
    assert_min_one_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && cond_ref) |=> blk);

    // R10: without an active reference the tail never grows
    assert_no_extend_R10: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cond_ref) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/mindb_combine.sv
module mindb_combine
    import mindb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pol,
    input  logic pwm,
    input  logic blk,
    output logic out
);

    logic gated;

    always_comb begin
        if (!en)
            gated = pwm;
        else if (pol)
            gated = pwm | blk;
        else
            gated = pwm & ~blk;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out <= 1'b0;
        else
            out <= gated;
    end

    // R2: disabled channel is a one-cycle delayed copy of its PWM
    assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && !en) |=> (out == $past(pwm)));

    // R8: force polarity drives high while blocked
    assert_force_high_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && pol && blk) |=> out);

    // R8: inhibit polarity drives low while blocked
    assert_inhibit_low_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && !pol && blk) |=> !out);

endmodule

// File: rtl/mindb_guard.sv
module mindb_guard
    import mindb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               rd_addr,
    output logic [31:0]        rd_data,
    input  logic               pwm_a,
    input  logic               pwm_b,
    input  logic               pre_db_a,
    input  logic               pre_db_b,
    input  logic [14:0]        ext_ref,
    output logic               out_a,
    output logic               out_b
);

    chan_cfg_t [NUM_CH-1:0]        cfg;
    logic [NUM_CH-1:0][DLY_W-1:0]  dly;
    logic [NUM_CH-1:0]             pwm_v;
    logic [NUM_CH-1:0]             own_v;
    logic [NUM_CH-1:0]             cond_v;
    logic [NUM_CH-1:0]             blk_v;
    logic [NUM_CH-1:0]             out_v;

    assign pwm_v = {pwm_b, pwm_a};
    assign own_v = {pre_db_b, pre_db_a};
    assign out_a = out_v[0];
    assign out_b = out_v[1];

    mindb_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_o   (cfg),
        .dly_o   (dly)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic blk_use;

        mindb_ref_sel u_sel (
            .own_ref  (own_v[ch]),
            .ext_ref  (ext_ref),
            .sel      (cfg[ch].sel),
            .inv      (cfg[ch].inv),
            .cond_ref (cond_v[ch])
        );

        mindb_stretch u_str (
            .clk      (clk),
            .rst      (rst),
            .cond_ref (cond_v[ch]),
            .dly      (dly[ch]),
            .blk      (blk_v[ch])
        );

        assign blk_use = cfg[ch].blk_other ? blk_v[NUM_CH-1-ch] : blk_v[ch];

        mindb_combine u_cmb (
            .clk (clk),
            .rst (rst),
            .en  (cfg[ch].en),
            .pol (cfg[ch].pol),
            .pwm (pwm_v[ch]),
            .blk (blk_use),
            .out (out_v[ch])
        );
    end

    // R1: outputs held low while in reset
    assert_out_reset_R1: assert property (@(posedge clk)
        rst |=> (out_a == 1'b0 && out_b == 1'b0));

endmodule

// File: tb/mindb_guard_bench.sv
module mindb_guard_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic        wr_addr;
    logic [31:0] wr_data;
    logic        rd_addr;
    logic [31:0] rd_data;
    logic        pwm_a, pwm_b, pre_db_a, pre_db_b;
    logic [14:0] ext_ref;
    logic        out_a, out_b;

    int n_chk = 0;
    int n_err = 0;

    // {pwm_a, pre_db_a, expected out_a}; channel A enabled, delay 3, inhibit
    localparam logic [2:0] VEC [0:13] = '{
        3'b110, 3'b100, 3'b100, 3'b100, 3'b101, 3'b000, 3'b110,
        3'b000, 3'b100, 3'b110, 3'b100, 3'b100, 3'b100, 3'b101
    };

    mindb_guard u_mindb_guard (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pwm_a    (pwm_a),
        .pwm_b    (pwm_b),
        .pre_db_a (pre_db_a),
        .pre_db_b (pre_db_b),
        .ext_ref  (ext_ref),
        .out_a    (out_a),
        .out_b    (out_b)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        pwm_a = 0; pwm_b = 0; pre_db_a = 0; pre_db_b = 0; ext_ref = '0;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(CLK_P * 100000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1; wr_en = 0; wr_addr = 0; wr_data = '0; rd_addr = 0;
        pwm_a = 1; pwm_b = 1; pre_db_a = 0; pre_db_b = 0; ext_ref = '0;
        #1;
        step(); step();
        // R1: outputs low in reset, fields zero
        chk("R1 out_a", out_a, 0);
        chk("R1 out_b", out_b, 0);
        rst = 0;
        rd(0, d); chk("R1 ctrl", d, 0);
        rd(1, d); chk("R1 dly", d, 0);

        // R2: disabled channel passes PWM despite active reference
        pre_db_a = 1; pwm_a = 1; pwm_b = 0; step();
        chk("R2 a high", out_a, 1);
        chk("R2 b low", out_b, 0);
        pwm_a = 0; step();
        chk("R2 a low", out_a, 0);
        idle(4);

        // R5: table walk
        wr(1, 32'h0000_0003);
        wr(0, 32'h0000_0001);
        idle(2);
        foreach (VEC[i]) begin
            pwm_a = VEC[i][2]; pre_db_a = VEC[i][1];
            step();
            chk($sformatf("R5 vec %0d", i), out_a, VEC[i][0]);
        end
        idle(5);

        // R6: zero delay stretches one cycle
        wr(1, 32'h0000_0000);
        pwm_a = 1; pre_db_a = 1; step(); chk("R6 ref high", out_a, 0);
        pre_db_a = 0; step(); chk("R6 one cycle", out_a, 0);
        step(); chk("R6 released", out_a, 1);
        idle(3);

        // R3: external code 5 selects ext_ref[4]; own input ignored
        wr(0, 32'h0000_0051);
        pwm_a = 1; pre_db_a = 1; step(); chk("R3 own ignored", out_a, 1);
        ext_ref[3] = 1; step(); chk("R3 other ext ignored", out_a, 1);
        ext_ref[4] = 1; step(); chk("R3 ext4 blocks", out_a, 0);
        ext_ref = '0; step(); chk("R3 tail", out_a, 0);
        step(); chk("R3 free", out_a, 1);
        idle(3);

        // R4: inverted reference
        pre_db_a = 1;
        wr(0, 32'h0000_0005);
        pwm_a = 1; step(); step();
        chk("R4 high ref passes", out_a, 1);
        pre_db_a = 0; step(); chk("R4 low ref blocks", out_a, 0);
        pre_db_a = 1; step(); chk("R4 tail", out_a, 0);
        step(); chk("R4 free", out_a, 1);
        idle(3);

        // R8: force polarity
        wr(0, 32'h0000_0101);
        pwm_a = 0; pre_db_a = 1; step(); chk("R8 forced", out_a, 1);
        pre_db_a = 0; step(); chk("R8 forced tail", out_a, 1);
        step(); chk("R8 forced end", out_a, 0);
        idle(3);

        // R7: channel B borrows channel A's pulse
        wr(1, 32'h0000_0002);
        wr(0, 32'h0009_0000);
        pwm_b = 1; pre_db_a = 1; step(); chk("R7 borrowed block", out_b, 0);
        pre_db_a = 0; step(); chk("R7 tail 1", out_b, 0);
        step(); chk("R7 tail 2", out_b, 0);
        step(); chk("R7 free", out_b, 1);
        pre_db_b = 1; step(); chk("R7 own ignored", out_b, 1);
        wr(0, 32'h0001_0000); step();
        chk("R7 own used", out_b, 0);
        idle(4);

        // R10: delay rewrite mid-stretch
        wr(1, 32'h0000_0004);
        wr(0, 32'h0000_0001);
        pwm_a = 1; pre_db_a = 1; step(); chk("R10 ref", out_a, 0);
        pre_db_a = 0; wr(1, 32'h0000_0001); chk("R10 tail 1", out_a, 0);
        step(); chk("R10 tail 2", out_a, 0);
        step(); chk("R10 tail 3", out_a, 0);
        step(); chk("R10 tail 4", out_a, 0);
        step(); chk("R10 end", out_a, 1);
        pre_db_a = 1; step(); pre_db_a = 0; step();
        chk("R10 new tail", out_a, 0);
        step(); chk("R10 new end", out_a, 1);
        idle(6);

        // R9: reserved bits and layout
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); chk("R9 ctrl mask", d, 32'h01FD_01FD);
        wr(1, 32'hA5C3_1234);
        rd(1, d); chk("R9 dly fields", d, 32'hA5C3_1234);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule